// File: doc/BRIEF.md
# Latch-Flop Universal Bus Transceiver

This block moves 20-bit words between an A side and a B side, one storage lane per direction. Each lane can pass its source straight through, hold its stored word, or capture the source on a rising edge of the lane's own strobe clock. Four controls select the behaviour of each lane. The latch enable is active high. The clock enable, the strobe clock and the output enable (active low) complete the set. Tri-state pads are modelled as a data vector plus a drive-enable bit per side. The pad itself is left to the chip level.

The lane strobe clocks are treated as data. They are sampled on the block's system clock `clk`, and a capture happens on the first `clk` edge that sees a strobe high after it was seen low. A test-mode input takes both sides away from the functional path. While it is high, each side's data and drive enable come from a test source and neither lane's stored word changes.

Top module: `ubt_xcvr`

## Requirements
- R1: With `test_mode` low and a lane's latch enable high, that lane's destination data equals its source data in the same cycle (A-to-B: `b_dout == a_in`; B-to-A: `a_dout == b_in`).
- R2: With latch enable low and the active-low clock enable high, the stored word does not change, whatever the strobe clock does; the destination shows the stored word.
- R3: With latch enable low and clock enable low, a strobe sampled high on a `clk` edge after being sampled low on the previous edge loads the source word sampled on that edge; the destination shows it from then on.
- R4: With latch enable low and clock enable low, a strobe sampled at the same level on consecutive edges, whether low or high, leaves the stored word unchanged.
- R5: In normal mode a side's drive enable is the inverse of its lane's active-low output enable (`b_oe = !ab_oe_n`, `a_oe = !ba_oe_n`).
- R6: The two lanes are independent: controls and data of one lane never change the other lane's stored word or outputs.
- R7: While `test_mode` is high, `a_dout`/`a_oe`/`b_dout`/`b_oe` equal `tst_a_dout`/`tst_a_oe`/`tst_b_dout`/`tst_b_oe`, and no stored word changes; after `test_mode` falls, the words held before it rose are visible again.
- R8: Latch enable outranks clock enable: a strobe edge while latch enable is high has no extra effect, and when latch enable falls the stored word is the source sampled on the last edge with latch enable high.
- R9: Synchronous active-high `rst` clears both stored words to zero and marks both strobes as previously high, so a strobe already high when reset is released is not taken as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state and strobe sampling on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | High hands both sides to the test source and freezes storage |
| a_in | input | 20 | Data seen on the A side (A-to-B source) |
| b_in | input | 20 | Data seen on the B side (B-to-A source) |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable, active high |
| ab_clken_n | input | 1 | A-to-B clock enable, active low |
| ab_clk | input | 1 | A-to-B strobe clock, sampled on `clk` |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, active high |
| ba_clken_n | input | 1 | B-to-A clock enable, active low |
| ba_clk | input | 1 | B-to-A strobe clock, sampled on `clk` |
| tst_a_dout | input | 20 | Test-source data for the A side |
| tst_a_oe | input | 1 | Test-source drive enable for the A side |
| tst_b_dout | input | 20 | Test-source data for the B side |
| tst_b_oe | input | 1 | Test-source drive enable for the B side |
| b_dout | output | 20 | Data driven toward the B side |
| b_oe | output | 1 | Drive enable for the B side |
| a_dout | output | 20 | Data driven toward the A side |
| a_oe | output | 1 | Drive enable for the A side |

## Verification
The bench walks every combination of latch enable, clock enable, output enable and strobe level through both lanes. Each lane gets its own code sequence, and fresh pseudo-random data is applied every cycle. Because the strobe level alternates between steps, the same enable settings are seen both with and without a rising edge. This separates a true capture from a static-high or static-low strobe, and a held lane from a clocked one. One pass runs in test mode with changing lane controls. The first checks after that pass show that storage stayed frozen. Directed sequences cover reset release with a strobe already high, and an edge under latch enable followed by latch enable falling. They also cover one lane capturing while the other lane holds. Every sample also checks that the two sides are never driven together.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    localparam int NDIR   = 2;
    localparam int DIR_AB = 0;
    localparam int DIR_BA = 1;

    typedef struct packed {
        logic oe_n;
        logic le;
        logic clken_n;
        logic strobe;
    } dir_ctrl_t;

    typedef enum logic [1:0] {
        MODE_PASS    = 2'd0,
        MODE_HOLD    = 2'd1,
        MODE_CLOCKED = 2'd2
    } lane_mode_e;

    // latch enable wins over clock enable
    function automatic lane_mode_e pick_mode(input dir_ctrl_t c);
        if (c.le)
            return MODE_PASS;
        else if (c.clken_n)
            return MODE_HOLD;
        else
            return MODE_CLOCKED;
    endfunction

endpackage

// File: rtl/ubt_rise_det.sv
module ubt_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic prev_q;

    // reset to high so a strobe already high at release is not an edge
    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b1;
        else
            prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/ubt_lane.sv
module ubt_lane
    import ubt_pkg::*;
#(
    parameter int W = 20
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      freeze,
    input  dir_ctrl_t ctrl,
    input  logic [W-1:0] src,
    output logic [W-1:0] dout,
    output logic      drive
);
    lane_mode_e   mode;
    logic         strobe_rise;
    logic [W-1:0] store_q;

    assign mode = pick_mode(ctrl);

    ubt_rise_det edge_i (
        .clk  (clk),
        .rst  (rst),
        .lvl  (ctrl.strobe),
        .rise (strobe_rise)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else if (!freeze) begin
            unique case (mode)
                MODE_PASS:    store_q <= src;
                MODE_CLOCKED: if (strobe_rise) store_q <= src;
                default:      store_q <= store_q;
            endcase
        end
    end

    assign dout  = (mode == MODE_PASS) ? src : store_q;
    assign drive = ~ctrl.oe_n;
endmodule

// File: rtl/ubt_test_mux.sv
module ubt_test_mux #(
    parameter int W = 20
) (
    input  logic         sel_test,
    input  logic [W-1:0] fn_data,
    input  logic         fn_en,
    input  logic [W-1:0] tst_data,
    input  logic         tst_en,
    output logic [W-1:0] out_data,
    output logic         out_en
);
    always_comb begin
        if (sel_test) begin
            out_data = tst_data;
            out_en   = tst_en;
        end else begin
            out_data = fn_data;
            out_en   = fn_en;
        end
    end
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
    import ubt_pkg::*;
#(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         test_mode,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_oe_n,
    input  logic         ab_le,
    input  logic         ab_clken_n,
    input  logic         ab_clk,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_clken_n,
    input  logic         ba_clk,
    input  logic [W-1:0] tst_a_dout,
    input  logic         tst_a_oe,
    input  logic [W-1:0] tst_b_dout,
    input  logic         tst_b_oe,
    output logic [W-1:0] b_dout,
    output logic         b_oe,
    output logic [W-1:0] a_dout,
    output logic         a_oe
);
    dir_ctrl_t    ctl      [NDIR];
    logic [W-1:0] src      [NDIR];
    logic [W-1:0] fn_data  [NDIR];
    logic         fn_en    [NDIR];
    logic [W-1:0] tst_data [NDIR];
    logic         tst_en   [NDIR];
    logic [W-1:0] out_data [NDIR];
    logic         out_en   [NDIR];

    assign ctl[DIR_AB] = '{oe_n: ab_oe_n, le: ab_le, clken_n: ab_clken_n, strobe: ab_clk};
    assign ctl[DIR_BA] = '{oe_n: ba_oe_n, le: ba_le, clken_n: ba_clken_n, strobe: ba_clk};

    assign src[DIR_AB]      = a_in;
    assign src[DIR_BA]      = b_in;
    assign tst_data[DIR_AB] = tst_b_dout;
    assign tst_en[DIR_AB]   = tst_b_oe;
    assign tst_data[DIR_BA] = tst_a_dout;
    assign tst_en[DIR_BA]   = tst_a_oe;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        ubt_lane #(.W(W)) lane_i (
            .clk    (clk),
            .rst    (rst),
            .freeze (test_mode),
            .ctrl   (ctl[d]),
            .src    (src[d]),
            .dout   (fn_data[d]),
            .drive  (fn_en[d])
        );

        ubt_test_mux #(.W(W)) mux_i (
            .sel_test (test_mode),
            .fn_data  (fn_data[d]),
            .fn_en    (fn_en[d]),
            .tst_data (tst_data[d]),
            .tst_en   (tst_en[d]),
            .out_data (out_data[d]),
            .out_en   (out_en[d])
        );
    end

    assign b_dout = out_data[DIR_AB];
    assign b_oe   = out_en[DIR_AB];
    assign a_dout = out_data[DIR_BA];
    assign a_oe   = out_en[DIR_BA];
endmodule

// File: rtl/ubt_xcvr_checker.sv
module ubt_xcvr_checker #(
    parameter int W = 20
) (
    input logic         clk,
    input logic         rst,
    input logic         test_mode,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         ab_oe_n,
    input logic         ab_le,
    input logic         ab_clken_n,
    input logic         ab_clk,
    input logic         ba_oe_n,
    input logic         ba_le,
    input logic         ba_clken_n,
    input logic         ba_clk,
    input logic [W-1:0] tst_a_dout,
    input logic         tst_a_oe,
    input logic [W-1:0] tst_b_dout,
    input logic         tst_b_oe,
    input logic [W-1:0] b_dout,
    input logic         b_oe,
    input logic [W-1:0] a_dout,
    input logic         a_oe
);
    assert_pass_ab_R1: assert property (@(posedge clk) disable iff (rst)
        (ab_le && !test_mode) |-> (b_dout == a_in));
    assert_pass_ba_R1: assert property (@(posedge clk) disable iff (rst)
        (ba_le && !test_mode) |-> (a_dout == b_in));

    assert_hold_ab_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!ab_le && ab_clken_n && !test_mode) && !ab_le && !test_mode)
        |-> $stable(b_dout));
    assert_hold_ba_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!ba_le && ba_clken_n && !test_mode) && !ba_le && !test_mode)
        |-> $stable(a_dout));

    assert_capture_ab_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !test_mode && !ab_le && !ab_clken_n && ab_clk && !$past(ab_clk))
        |=> ((ab_le || test_mode) || (b_dout == $past(a_in))));

    assert_oe_ab_R5: assert property (@(posedge clk) disable iff (rst)
        !test_mode |-> (b_oe == !ab_oe_n));
    assert_oe_ba_R5: assert property (@(posedge clk) disable iff (rst)
        !test_mode |-> (a_oe == !ba_oe_n));

    assert_test_src_R7: assert property (@(posedge clk) disable iff (rst)
        test_mode |-> (b_dout == tst_b_dout && a_dout == tst_a_dout
                       && b_oe == tst_b_oe && a_oe == tst_a_oe));

    assert_reset_zero_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !ab_le && !test_mode) |-> (b_dout == '0));
endmodule

bind ubt_xcvr ubt_xcvr_checker #(.W(W)) chk_i (.*);

// File: tb/ubt_xcvr_tb_top.sv
module ubt_xcvr_tb_top;
    localparam int W = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic test_mode = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0, tst_a_dout = '0, tst_b_dout = '0;
    logic tst_a_oe = 1'b0, tst_b_oe = 1'b0;
    logic le_v [2], cen_v [2], oen_v [2], dck_v [2];
    logic [W-1:0] b_dout, a_dout;
    logic b_oe, a_oe;

    always #5 clk = ~clk;

    ubt_xcvr #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .test_mode(test_mode),
        .a_in(a_in), .b_in(b_in),
        .ab_oe_n(oen_v[0]), .ab_le(le_v[0]), .ab_clken_n(cen_v[0]), .ab_clk(dck_v[0]),
        .ba_oe_n(oen_v[1]), .ba_le(le_v[1]), .ba_clken_n(cen_v[1]), .ba_clk(dck_v[1]),
        .tst_a_dout(tst_a_dout), .tst_a_oe(tst_a_oe),
        .tst_b_dout(tst_b_dout), .tst_b_oe(tst_b_oe),
        .b_dout(b_dout), .b_oe(b_oe), .a_dout(a_dout), .a_oe(a_oe)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    logic [W-1:0] m_st [2];
    logic         m_prev [2];
    string        m_kind [2];
    logic [W-1:0] rng = 20'h5A3C1;

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] next_rand(input logic [W-1:0] v);
        logic [W-1:0] x;
        x = v;
        x = x ^ (x << 7);
        x = x ^ (x >> 9);
        x = x ^ (x << 3);
        if (x == '0) x = 20'h1;
        return x;
    endfunction

    // compare outputs with the requirement model, after inputs settle
    task automatic settle_check();
        logic [W-1:0] exp_d [2];
        logic         exp_e [2];
        logic [W-1:0] srcv [2];
        string        tag [2];
        #1;
        srcv[0] = a_in;
        srcv[1] = b_in;
        for (int d = 0; d < 2; d++) begin
            if (test_mode) begin
                exp_d[d] = (d == 0) ? tst_b_dout : tst_a_dout;
                exp_e[d] = (d == 0) ? tst_b_oe : tst_a_oe;
                tag[d]   = "R7";
            end else begin
                exp_d[d] = le_v[d] ? srcv[d] : m_st[d];
                exp_e[d] = ~oen_v[d];
                tag[d]   = le_v[d] ? "R1" : m_kind[d];
            end
        end
        check(tag[0], "b_dout", b_dout, exp_d[0]);
        check(tag[1], "a_dout", a_dout, exp_d[1]);
        check(test_mode ? "R7" : "R5", "b_oe", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, exp_e[0]});
        check(test_mode ? "R7" : "R5", "a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, exp_e[1]});
        n_chk++;
        if (a_oe && b_oe) begin
            n_err++;
            $display("FAIL R5 contention: actual a_oe=1 b_oe=1 expected not both");
        end
    endtask

    // advance one clk edge and update the model from the driven values
    task automatic clock_model();
        logic [W-1:0] srcv [2];
        @(posedge clk);
        srcv[0] = a_in;
        srcv[1] = b_in;
        for (int d = 0; d < 2; d++) begin
            if (rst) begin
                m_st[d]   = '0;
                m_prev[d] = 1'b1;
                m_kind[d] = "R9";
            end else begin
                if (!test_mode) begin
                    if (le_v[d]) begin
                        m_st[d]   = srcv[d];
                        m_kind[d] = "R8";
                    end else if (!cen_v[d] && dck_v[d] && !m_prev[d]) begin
                        m_st[d]   = srcv[d];
                        m_kind[d] = "R3";
                    end else begin
                        m_kind[d] = cen_v[d] ? "R2" : "R4";
                    end
                end
                m_prev[d] = dck_v[d];
            end
        end
        #1;
    endtask

    task automatic set_dir(input int d, input logic [3:0] code);
        le_v[d]  = code[3];
        cen_v[d] = code[2];
        oen_v[d] = code[1];
        dck_v[d] = code[0];
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v1, v2, held_a;
        for (int d = 0; d < 2; d++) begin
            m_st[d] = '0; m_prev[d] = 1'b1; m_kind[d] = "R9";
        end
        // R9: reset with strobes already high, held high through release
        set_dir(0, 4'b0001);
        set_dir(1, 4'b0011);
        a_in = 20'hABCDE; b_in = 20'h12345;
        rst = 1'b1;
        repeat (3) clock_model();
        rst = 1'b0;
        clock_model();
        clock_model();
        #1;
        check("R9", "b_dout after reset, strobe high", b_dout, '0);
        check("R9", "a_dout after reset", a_dout, '0);

        // exhaustive control sweep over both lanes
        for (int pass = 0; pass < 6; pass++) begin
            for (int c = 0; c < 16; c++) begin
                logic [3:0] ca, cb;
                ca = 4'(c) ^ 4'((pass * 6) & 14);
                cb = 4'((c * 7 + pass * 5) & 15);
                if (!ca[1]) cb[1] = 1'b1;
                test_mode = (pass == 3);
                rng = next_rand(rng); a_in = rng;
                rng = next_rand(rng); b_in = rng;
                rng = next_rand(rng); tst_a_dout = rng;
                rng = next_rand(rng); tst_b_dout = rng;
                tst_a_oe = rng[0];
                tst_b_oe = ~rng[0];
                set_dir(0, ca);
                set_dir(1, cb);
                settle_check();
                clock_model();
            end
            if (pass == 3) begin
                // R7: storage frozen during test mode, visible after exit
                test_mode = 1'b0;
                set_dir(0, 4'b0101);
                set_dir(1, 4'b0111);
                settle_check();
                check("R7", "b_dout retained after test mode", b_dout, m_st[0]);
                clock_model();
            end
        end

        // R8: edge under latch enable, then latch enable falls
        test_mode = 1'b0;
        set_dir(1, 4'b0111);
        set_dir(0, 4'b1000);
        v1 = 20'h0F0F1; a_in = v1;
        settle_check();
        clock_model();
        set_dir(0, 4'b1001);
        v2 = 20'hC3A5F; a_in = v2;
        settle_check();
        clock_model();
        set_dir(0, 4'b0001);
        a_in = 20'h77777;
        settle_check();
        check("R8", "b_dout holds last transparent value", b_dout, v2);
        clock_model();

        // R6: A-to-B captures while B-to-A holds
        set_dir(1, 4'b0111);
        b_in = 20'h31415;
        settle_check();
        held_a = a_dout;
        clock_model();
        set_dir(0, 4'b0000);
        a_in = 20'h24680;
        settle_check();
        clock_model();
        set_dir(0, 4'b0001);
        b_in = 20'hFFFFF;
        settle_check();
        clock_model();
        #1;
        check("R3", "b_dout captured on strobe edge", b_dout, 20'h24680);
        check("R6", "a_dout unaffected by other lane", a_dout, held_a);

        // R4: static-high strobe, no capture
        a_in = 20'h13579;
        settle_check();
        clock_model();
        #1;
        check("R4", "b_dout with static strobe", b_dout, 20'h24680);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule